// File: doc/BRIEF.md
# CAN Frame Field Parser

This block sits behind a CAN bit sampler and stuff-bit detector. It receives one sampled bus bit per strobe. Each bit carries a flag that marks it as a stuff bit and a flag that marks it as the start-of-frame bit. The parser counts only real (de-stuffed) bits. It follows the frame from the start bit to the last end-of-frame bit and exposes every field on its outputs as the field arrives: base and extended identifier, the remote-request, substitute-request and identifier-extension bits, the reserved bits, the length code, the data bytes, the received CRC sequence and the acknowledge slot.

The layout splits at the identifier-extension bit into a short-identifier form and a long-identifier form. The end of the data field depends on the length code, so the CRC, delimiters, acknowledge slot and end-of-frame bits are all located relative to the last data bit. A separate checker compares the CRC; this block only reports the received sequence. A dominant bit where the frame requires recessive sets a sticky form-error output. When the frame completes, a one-cycle done strobe is raised and the parser returns to idle.

Top module: `can_frame_parser`

## Requirements
- R1: A strobed bit with `bit_stuff` = 1 is ignored entirely. It does not advance the bit position, is not stored in any field, and does not start or abort a frame even when `bit_sof` is also 1.
- R2: Reset clears all outputs to 0. While idle, bits without `bit_sof` are ignored. A real bit with `bit_sof` = 1 and value 0 (dominant) is bit 0: it starts a frame and clears all fields and `form_err`. A real bit with `bit_sof` = 1 and value 1 raises `sof_err` for exactly one cycle and leaves the block idle, which abandons any frame in progress.
- R3: Bits 1 to 11 load `base_id`, first received bit in `base_id[10]`.
- R4: Bit 13 drives `ide` (0 = short layout, 1 = long layout). Bit 12 goes to `rtr` when `ide` = 0 (1 = remote frame) and to `srr` when `ide` = 1. In the short layout `srr` stays 0.
- R5: Short layout: bit 14 is `rb0`, and bits 15 to 18 are `dlc` with the first bit received as its MSB. `ext_id` and `rb1` stay 0.
- R6: Long layout: bits 14 to 31 load `ext_id` MSB first, bit 32 is `rtr`, bit 33 is `rb1`, bit 34 is `rb0`, and bits 35 to 38 are `dlc` MSB first. `full_id` equals `{base_id, ext_id}`, which is (base << 18) | extended.
- R7: `data_len` = min(`dlc`, 8), or 0 when `rtr` = 1. The next 8 × `data_len` bits after the length code fill the data bytes MSB first. Byte k lands in `data_out[8k+7:8k]`, and bytes that are not received read 0.
- R8: The 15 bits after the last data bit load `crc_seq`, first received bit in `crc_seq[14]`.
- R9: At offset 17 after the last data bit, `ack` becomes 1 for a dominant bit and 0 for a recessive bit.
- R10: A dominant bit at offset 16 (CRC delimiter), 18 (acknowledge delimiter) or 19 to 25 (end of frame) sets `form_err`. `form_err` stays 1 until the next frame start.
- R11: One clock edge after the strobe of the bit at offset 25, `frame_done` is 1 for exactly one cycle and the block is idle. All fields keep their values until the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_stb | input | 1 | One sampled bus bit is presented this cycle |
| bit_val | input | 1 | Bit value, 0 dominant, 1 recessive |
| bit_stuff | input | 1 | The strobed bit is a stuff bit |
| bit_sof | input | 1 | The strobed bit is the start-of-frame bit |
| base_id | output | 11 | Base identifier |
| ext_id | output | 18 | Extended identifier |
| full_id | output | 29 | Base and extended identifier joined |
| ide | output | 1 | Identifier extension bit |
| rtr | output | 1 | Remote request bit |
| srr | output | 1 | Substitute remote request bit |
| rb0 | output | 1 | Reserved bit 0 |
| rb1 | output | 1 | Reserved bit 1 |
| dlc | output | 4 | Raw length code |
| data_len | output | 4 | Data bytes carried |
| data_out | output | 64 | Data bytes, byte k at bits 8k+7..8k |
| crc_seq | output | 15 | Received CRC sequence |
| ack | output | 1 | Acknowledge slot was dominant |
| sof_err | output | 1 | Recessive start-of-frame bit seen |
| form_err | output | 1 | Fixed-form bit found dominant |
| frame_done | output | 1 | Frame complete strobe |

## Verification
The sharpest coincidence is a dominant final end-of-frame bit. It sets `form_err` on the same edge that raises `frame_done`, so the monitor checks that the completion it pops already carries the error flag. A second collision follows from that frame: the next frame's start bit is driven in the very next strobe. The done strobe and the new start therefore sit on adjacent edges. The scoreboard must still see the old frame's fields while `frame_done` is high and clean fields with a cleared error for the next frame.

// File: rtl/can_parse_pkg.sv
package can_parse_pkg;

    localparam int BASE_W    = 11;
    localparam int EXT_W     = 18;
    localparam int DLC_W     = 4;
    localparam int LEN_W     = 4;
    localparam int CRC_W     = 15;
    localparam int MAX_BYTES = 8;
    localparam int DATA_W    = MAX_BYTES * 8;
    localparam int POS_W     = 7;

    typedef logic [POS_W-1:0] pos_t;

    // head positions (de-stuffed bit index from start bit = 0)
    localparam pos_t P_BASE_FIRST  = 7'd1;
    localparam pos_t P_BASE_LAST   = 7'd11;
    localparam pos_t P_BIT12       = 7'd12;
    localparam pos_t P_IDE         = 7'd13;
    localparam pos_t P_STD_RB0     = 7'd14;
    localparam pos_t P_STD_DLC_END = 7'd18;
    localparam pos_t P_EXT_ID_LAST = 7'd31;
    localparam pos_t P_EXT_RTR     = 7'd32;
    localparam pos_t P_EXT_RB1     = 7'd33;
    localparam pos_t P_EXT_RB0     = 7'd34;
    localparam pos_t P_EXT_DLC_END = 7'd38;

    // tail offsets relative to the last data bit
    localparam pos_t T_CRC_LAST = 7'd15;
    localparam pos_t T_ACK_SLOT = 7'd17;
    localparam pos_t T_EOF_LAST = 7'd25;

    typedef struct packed {
        logic [BASE_W-1:0] base_id;
        logic [EXT_W-1:0]  ext_id;
        logic              ide;
        logic              rtr;
        logic              srr;
        logic              rb0;
        logic              rb1;
        logic [DLC_W-1:0]  dlc;
        logic [LEN_W-1:0]  data_len;
        logic [DATA_W-1:0] data;
        logic [CRC_W-1:0]  crc;
        logic              ack;
    } can_fields_t;

    function automatic logic [LEN_W-1:0] clamp_len(input logic [DLC_W-1:0] code,
                                                   input logic remote);
        if (remote)
            return '0;
        else if (code > 4'd8)
            return 4'd8;
        else
            return code;
    endfunction

    function automatic pos_t data_end_pos(input pos_t dlc_end,
                                          input logic [LEN_W-1:0] len);
        return dlc_end + {len, 3'b000};
    endfunction

endpackage

// File: rtl/can_bit_tracker.sv
module can_bit_tracker
    import can_parse_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_stb,
    input  logic bit_val,
    input  logic bit_stuff,
    input  logic bit_sof,
    input  logic frame_end,
    output logic start,
    output logic take,
    output pos_t pos,
    output logic sof_err,
    output logic frame_done
);
    logic active;
    logic real_bit;

    assign real_bit = bit_stb && !bit_stuff;
    assign start    = real_bit && bit_sof && !bit_val;
    assign take     = real_bit && active && !bit_sof;

    always_ff @(posedge clk) begin
        if (rst) begin
            active     <= 1'b0;
            pos        <= '0;
            sof_err    <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            sof_err    <= real_bit && bit_sof && bit_val;
            frame_done <= take && frame_end;
            if (start) begin
                active <= 1'b1;
                pos    <= P_BASE_FIRST;
            end else if (real_bit && bit_sof) begin
                active <= 1'b0;
            end else if (take) begin
                pos <= pos + 7'd1;
                if (frame_end)
                    active <= 1'b0;
            end
        end
    end

    // R1
    stuff_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_stb && bit_stuff) |=> ($stable(pos) && $stable(active)));

    // R2
    sof_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (real_bit && bit_sof && bit_val) |=> (sof_err && !active));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> !active);

endmodule

// File: rtl/can_field_decoder.sv
module can_field_decoder
    import can_parse_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        take,
    input  logic        bit_val,
    input  pos_t        pos,
    output can_fields_t fld,
    output logic        form_err,
    output logic        frame_end
);
    logic             bit12_q;
    logic             dlc_done_q;
    pos_t             last_q;
    pos_t             dlc_end;
    pos_t             toff;
    pos_t             rel;
    logic [DLC_W-1:0] dlc_next;
    logic [LEN_W-1:0] len_next;
    logic             in_data;
    logic             in_tail;

    always_comb begin
        dlc_end   = fld.ide ? P_EXT_DLC_END : P_STD_DLC_END;
        dlc_next  = {fld.dlc[DLC_W-2:0], bit_val};
        len_next  = clamp_len(dlc_next, fld.rtr);
        toff      = pos - last_q;
        rel       = pos - dlc_end - 7'd1;
        in_data   = dlc_done_q && (pos <= last_q);
        in_tail   = dlc_done_q && (pos > last_q);
        frame_end = take && in_tail && (toff == T_EOF_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst || start) begin
            fld        <= '0;
            bit12_q    <= 1'b0;
            dlc_done_q <= 1'b0;
            last_q     <= '0;
            form_err   <= 1'b0;
        end else if (take) begin
            if (pos <= P_BASE_LAST) begin
                fld.base_id <= {fld.base_id[BASE_W-2:0], bit_val};
            end else if (pos == P_BIT12) begin
                bit12_q <= bit_val;
            end else if (pos == P_IDE) begin
                fld.ide <= bit_val;
                if (bit_val)
                    fld.srr <= bit12_q;
                else
                    fld.rtr <= bit12_q;
            end else if (!dlc_done_q) begin
                if (!fld.ide) begin
                    if (pos == P_STD_RB0)
                        fld.rb0 <= bit_val;
                    else
                        fld.dlc <= dlc_next;
                end else begin
                    if (pos <= P_EXT_ID_LAST)
                        fld.ext_id <= {fld.ext_id[EXT_W-2:0], bit_val};
                    else if (pos == P_EXT_RTR)
                        fld.rtr <= bit_val;
                    else if (pos == P_EXT_RB1)
                        fld.rb1 <= bit_val;
                    else if (pos == P_EXT_RB0)
                        fld.rb0 <= bit_val;
                    else
                        fld.dlc <= dlc_next;
                end
                if (pos == dlc_end) begin
                    dlc_done_q   <= 1'b1;
                    fld.data_len <= len_next;
                    last_q       <= data_end_pos(dlc_end, len_next);
                end
            end else if (in_data) begin
                fld.data[{rel[5:3], ~rel[2:0]}] <= bit_val;
            end else begin
                if (toff <= T_CRC_LAST)
                    fld.crc <= {fld.crc[CRC_W-2:0], bit_val};
                else if (toff == T_ACK_SLOT)
                    fld.ack <= !bit_val;
                else if (!bit_val)
                    form_err <= 1'b1;
            end
        end
    end

    // R7
    len_cap_chk: assert property (@(posedge clk) disable iff (rst)
        fld.data_len <= 4'd8);

    // R7
    remote_len_chk: assert property (@(posedge clk) disable iff (rst)
        (dlc_done_q && fld.rtr) |-> (fld.data_len == 4'd0));

    // R7
    data_index_chk: assert property (@(posedge clk) disable iff (rst)
        (take && in_data) |-> !rel[6]);

    // R10
    form_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (form_err && !start) |=> form_err);

endmodule

// File: rtl/can_frame_parser.sv
module can_frame_parser
    import can_parse_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bit_stb,
    input  logic                    bit_val,
    input  logic                    bit_stuff,
    input  logic                    bit_sof,
    output logic [BASE_W-1:0]       base_id,
    output logic [EXT_W-1:0]        ext_id,
    output logic [BASE_W+EXT_W-1:0] full_id,
    output logic                    ide,
    output logic                    rtr,
    output logic                    srr,
    output logic                    rb0,
    output logic                    rb1,
    output logic [DLC_W-1:0]        dlc,
    output logic [LEN_W-1:0]        data_len,
    output logic [DATA_W-1:0]       data_out,
    output logic [CRC_W-1:0]        crc_seq,
    output logic                    ack,
    output logic                    sof_err,
    output logic                    form_err,
    output logic                    frame_done
);
    logic        start;
    logic        take;
    logic        frame_end;
    pos_t        pos;
    can_fields_t fld;

    can_bit_tracker u_track (
        .clk        (clk),
        .rst        (rst),
        .bit_stb    (bit_stb),
        .bit_val    (bit_val),
        .bit_stuff  (bit_stuff),
        .bit_sof    (bit_sof),
        .frame_end  (frame_end),
        .start      (start),
        .take       (take),
        .pos        (pos),
        .sof_err    (sof_err),
        .frame_done (frame_done)
    );

    can_field_decoder u_dec (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .take      (take),
        .bit_val   (bit_val),
        .pos       (pos),
        .fld       (fld),
        .form_err  (form_err),
        .frame_end (frame_end)
    );

    assign base_id  = fld.base_id;
    assign ext_id   = fld.ext_id;
    assign full_id  = {fld.base_id, fld.ext_id};
    assign ide      = fld.ide;
    assign rtr      = fld.rtr;
    assign srr      = fld.srr;
    assign rb0      = fld.rb0;
    assign rb1      = fld.rb1;
    assign dlc      = fld.dlc;
    assign data_len = fld.data_len;
    assign data_out = fld.data;
    assign crc_seq  = fld.crc;
    assign ack      = fld.ack;

endmodule

// File: tb/tb_can_frame_parser.sv
module tb_can_frame_parser;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        bit_stb = 1'b0, bit_val = 1'b1, bit_stuff = 1'b0, bit_sof = 1'b0;
    logic [10:0] base_id;
    logic [17:0] ext_id;
    logic [28:0] full_id;
    logic        ide, rtr, srr, rb0, rb1, ack, sof_err, form_err, frame_done;
    logic [3:0]  dlc, data_len;
    logic [63:0] data_out;
    logic [14:0] crc_seq;

    can_frame_parser dut (
        .clk(clk), .rst(rst), .bit_stb(bit_stb), .bit_val(bit_val),
        .bit_stuff(bit_stuff), .bit_sof(bit_sof), .base_id(base_id),
        .ext_id(ext_id), .full_id(full_id), .ide(ide), .rtr(rtr), .srr(srr),
        .rb0(rb0), .rb1(rb1), .dlc(dlc), .data_len(data_len),
        .data_out(data_out), .crc_seq(crc_seq), .ack(ack), .sof_err(sof_err),
        .form_err(form_err), .frame_done(frame_done)
    );

    typedef struct {
        logic [10:0] base;
        logic [17:0] ext;
        logic        ide, rtr, srr, rb0, rb1, ack, ferr;
        logic [3:0]  dlc, len;
        logic [63:0] data;
        logic [14:0] crc;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    int   n_done = 0;
    int   n_sent = 0;
    bit   finished = 1'b0;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic put_bit(input logic v, input logic st, input logic sof);
        @(posedge clk);
        #1;
        bit_stb = 1'b1; bit_val = v; bit_stuff = st; bit_sof = sof;
    endtask

    task automatic gap();
        @(posedge clk);
        #1;
        bit_stb = 1'b0; bit_stuff = 1'b0; bit_sof = 1'b0; bit_val = 1'b1;
    endtask

    // bad: 0 none, else tail offset forced dominant (16, 18, 19..25)
    task automatic send_frame(input logic e_ide, input logic [10:0] b_id,
                              input logic [17:0] x_id, input logic rmt,
                              input logic s_bit, input logic r0, input logic r1,
                              input logic [3:0] code, input logic [63:0] dat,
                              input logic [14:0] crc, input logic acked,
                              input int bad, input bit trail_gap);
        logic q[$];
        exp_t e;
        int   len;
        int   run;
        logic prev;
        len = rmt ? 0 : ((code > 8) ? 8 : int'(code));
        q.push_back(1'b0);
        for (int i = 10; i >= 0; i--) q.push_back(b_id[i]);
        q.push_back(e_ide ? s_bit : rmt);
        q.push_back(e_ide);
        if (!e_ide) begin
            q.push_back(r0);
        end else begin
            for (int i = 17; i >= 0; i--) q.push_back(x_id[i]);
            q.push_back(rmt);
            q.push_back(r1);
            q.push_back(r0);
        end
        for (int i = 3; i >= 0; i--) q.push_back(code[i]);
        for (int k = 0; k < len; k++)
            for (int b = 7; b >= 0; b--) q.push_back(dat[8*k+b]);
        for (int i = 14; i >= 0; i--) q.push_back(crc[i]);
        q.push_back(bad == 16 ? 1'b0 : 1'b1);
        q.push_back(acked ? 1'b0 : 1'b1);
        q.push_back(bad == 18 ? 1'b0 : 1'b1);
        for (int i = 19; i <= 25; i++) q.push_back(bad == i ? 1'b0 : 1'b1);

        e.base = b_id; e.ext = e_ide ? x_id : 18'd0; e.ide = e_ide; e.rtr = rmt;
        e.srr = e_ide ? s_bit : 1'b0; e.rb0 = r0; e.rb1 = e_ide ? r1 : 1'b0;
        e.ack = acked; e.ferr = (bad != 0); e.dlc = code; e.len = 4'(len);
        e.data = '0;
        for (int k = 0; k < len; k++) e.data[8*k +: 8] = dat[8*k +: 8];
        e.crc = crc;
        exp_q.push_back(e);
        n_sent++;

        run = 0;
        prev = 1'bx;
        for (int i = 0; i < q.size(); i++) begin
            put_bit(q[i], 1'b0, i == 0);
            if (q[i] === prev) run++;
            else begin run = 1; prev = q[i]; end
            if (run == 5 && i < q.size() - 10) begin
                // R1: stuff bit, opposite polarity, sometimes with a sof mark too
                put_bit(!q[i], 1'b1, (i % 3) == 0);
                run = 1;
                prev = !q[i];
            end
            if (i % 9 == 8 && i != q.size() - 1) gap();
        end
        if (trail_gap) gap();
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        exp_t e;
        if (!rst && !finished && frame_done) begin
            n_done++;
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R11 unexpected frame_done: actual 1 expected 0");
            end else begin
                e = exp_q.pop_front();
                chk("R3", "base_id", 64'(base_id), 64'(e.base));
                chk("R4", "ide", 64'(ide), 64'(e.ide));
                chk("R4", "rtr", 64'(rtr), 64'(e.rtr));
                chk("R4", "srr", 64'(srr), 64'(e.srr));
                chk("R5", "rb0", 64'(rb0), 64'(e.rb0));
                chk("R5", "dlc", 64'(dlc), 64'(e.dlc));
                chk("R6", "ext_id", 64'(ext_id), 64'(e.ext));
                chk("R6", "rb1", 64'(rb1), 64'(e.rb1));
                chk("R6", "full_id", 64'(full_id), 64'({e.base, e.ext}));
                chk("R7", "data_len", 64'(data_len), 64'(e.len));
                chk("R7", "data_out", data_out, e.data);
                chk("R8", "crc_seq", 64'(crc_seq), 64'(e.crc));
                chk("R9", "ack", 64'(ack), 64'(e.ack));
                chk("R10", "form_err", 64'(form_err), 64'(e.ferr));
            end
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL R11 watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R2 reset state
        chk("R2", "reset frame_done", 64'(frame_done), 64'd0);
        chk("R2", "reset sof_err", 64'(sof_err), 64'd0);
        chk("R2", "reset form_err", 64'(form_err), 64'd0);
        chk("R2", "reset base_id", 64'(base_id), 64'd0);
        chk("R2", "reset data_out", data_out, 64'd0);

        // standard data frame, 2 bytes, acked
        send_frame(1'b0, 11'h5A3, 18'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2,
                   64'h0000_0000_0000_C381, 15'h1234, 1'b1, 0, 1'b1);
        // R2: unmarked dominant bits while idle are ignored
        put_bit(1'b0, 1'b0, 1'b0);
        put_bit(1'b0, 1'b0, 1'b0);
        put_bit(1'b0, 1'b0, 1'b0);
        gap();
        @(negedge clk);
        chk("R2", "idle bits ignored base_id", 64'(base_id), 64'h5A3);
        // R1: stuff-flagged dominant sof mark does not start a frame
        put_bit(1'b0, 1'b1, 1'b1);
        gap();
        @(negedge clk);
        chk("R1", "stuff sof ignored base_id", 64'(base_id), 64'h5A3);
        // R2: recessive sof-marked bit -> one-cycle sof_err
        put_bit(1'b1, 1'b0, 1'b1);
        gap();
        @(negedge clk);
        chk("R2", "sof_err pulse", 64'(sof_err), 64'd1);
        @(negedge clk);
        chk("R2", "sof_err falls", 64'(sof_err), 64'd0);

        // long-identifier data frame, 8 bytes, not acked
        send_frame(1'b1, 11'h7F0, 18'h2ABCD, 1'b0, 1'b1, 1'b0, 1'b1, 4'd8,
                   64'hFEDC_BA98_7654_3210, 15'h7FFF, 1'b0, 0, 1'b1);
        // short remote frame, dlc 5 -> no data
        send_frame(1'b0, 11'h001, 18'd0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd5,
                   64'hFFFF_FFFF_FFFF_FFFF, 15'h0001, 1'b1, 0, 1'b1);
        // dlc 12 clamped to 8 bytes
        send_frame(1'b0, 11'h3C3, 18'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd12,
                   64'h1122_3344_5566_7788, 15'h5555, 1'b1, 0, 1'b1);
        // long remote frame
        send_frame(1'b1, 11'h000, 18'h00003, 1'b1, 1'b1, 1'b1, 1'b1, 4'd3,
                   64'hAAAA_AAAA_AAAA_AAAA, 15'h2AAA, 1'b1, 0, 1'b1);
        // zero length
        send_frame(1'b0, 11'h2F1, 18'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0,
                   64'd0, 15'h4321, 1'b0, 0, 1'b1);
        // R10 dominant CRC delimiter
        send_frame(1'b0, 11'h111, 18'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd1,
                   64'h0000_0000_0000_005A, 15'h0F0F, 1'b1, 16, 1'b1);
        // R10 dominant acknowledge delimiter, long layout
        send_frame(1'b1, 11'h222, 18'h10001, 1'b0, 1'b1, 1'b0, 1'b0, 4'd3,
                   64'h0000_0000_00AB_CDEF, 15'h3333, 1'b1, 18, 1'b1);
        // R2: a frame abandoned by a recessive sof mark, then a good one
        put_bit(1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 6; i++) put_bit(i[0], 1'b0, 1'b0);
        put_bit(1'b1, 1'b0, 1'b1);
        gap();
        // R10/R11: last EOF bit dominant, next frame back-to-back
        send_frame(1'b0, 11'h6B9, 18'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3,
                   64'h0000_0000_0033_2211, 15'h1A2B, 1'b1, 25, 1'b0);
        send_frame(1'b1, 11'h4D2, 18'h3FFFF, 1'b0, 1'b1, 1'b0, 1'b0, 4'd4,
                   64'h0000_0000_DEAD_BEEF, 15'h6E5D, 1'b1, 0, 1'b1);

        repeat (5) @(posedge clk);
        @(negedge clk);
        // R11: every frame completed once, one pulse each
        chk("R11", "frames pending", 64'(exp_q.size()), 64'd0);
        chk("R11", "done pulses", 64'(n_done), 64'(n_sent));
        chk("R11", "done low at rest", 64'(frame_done), 64'd0);
        // R11: fields hold after completion
        chk("R11", "held base_id", 64'(base_id), 64'h4D2);
        chk("R11", "held data_out", data_out, 64'h0000_0000_DEAD_BEEF);
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule